// File: doc/BRIEF.md
# Registered Four-Bit Mode-Select ALU

This block combines two 4-bit operands under a 5-bit control code: one mode bit that picks the function class and a 4-bit select that picks one of sixteen functions within it. That gives 32 functions. In logic mode every result bit depends only on the matching operand bit pair. In arithmetic mode two select-shaped operand terms are summed through a ripple-carry chain together with an incoming carry.

Operands and controls are captured in flip-flops on a rising clock edge while the enable is high. The result, the carry-out, an all-ones flag and a group generate/propagate pair are then driven combinationally from those registers. The all-ones flag works as an equality compare when the subtract-minus-one function is selected. The generate and propagate outputs let several instances be joined into a wider unit. The active-low reset asserts asynchronously and is released through a synchronizer.

Top module: `alu4_mode_core`

## Requirements
- R1: After reset every output is 0: result 0000, carry_out 0, equal_flag 0, grp_gen 0, grp_prop 0.
- R2: On a rising edge with en=1 the operands, mode, select and carry_in are captured, and the outputs show the new function after that edge. With en=0 every output keeps its value whatever the inputs do.
- R3: With mode_logic=1 each result bit is this function of the operand bits a and b, by sel: 0000 ~a, 0001 ~(a|b), 0010 ~a&b, 0011 0, 0100 ~(a&b), 0101 ~b, 0110 a^b, 0111 a&~b, 1000 ~a|b, 1001 ~(a^b), 1010 b, 1011 a&b, 1100 1, 1101 a|~b, 1110 a|b, 1111 a.
- R4: With mode_logic=1 and sel=1011 the result is the bitwise AND, so a=1010 and b=0101 give 0000.
- R5: With mode_logic=0 the result is the low 4 bits of X+Y+carry_in, with X = A | (B&sel[0]) | (~B&sel[1]) and Y = (A&B&sel[3]) | (A&~B&sel[2]). This gives, for example, 1001 A+B, 0110 A-B-1, 1111 A-1, 1100 A+A, 0000 A, 0011 all ones.
- R6: carry_out is bit 4 of X+Y+carry_in in arithmetic mode and is 0 in logic mode.
- R7: With arithmetic sel=0110 and carry_in=1 the result is A-B mod 16, and carry_out=1 exactly when A>=B. With carry_in=0 and A=B, equal_flag is 1.
- R8: equal_flag is 1 exactly when the result is 1111, in either mode.
- R9: In arithmetic mode grp_prop is the AND over bits of (X|Y), grp_gen is the carry out of X+Y with no carry in, and carry_out = grp_gen | (grp_prop & carry_in). In logic mode both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| en | input | 1 | Capture enable for operands and controls |
| a_in | input | 4 | Operand A |
| b_in | input | 4 | Operand B |
| mode_logic | input | 1 | 1 selects logic functions, 0 selects arithmetic functions |
| sel | input | 4 | Function select within the class |
| carry_in | input | 1 | Carry into bit 0 (1 adds one) |
| result | output | 4 | Function result |
| carry_out | output | 1 | Carry from bit 3, 0 in logic mode |
| equal_flag | output | 1 | High when result is all ones |
| grp_gen | output | 1 | Group carry generate for cascading |
| grp_prop | output | 1 | Group carry propagate for cascading |

## Verification
Every output is due one clock edge after the capturing edge. The registers sit at the inputs and the result logic behind them has no further state. The bench therefore changes inputs on a falling edge, lets the next rising edge capture them, and compares all five outputs on the falling edge after that. With en low the expected values stay those of the last capture, and the hold checks sample in the same slot. Reset release goes through two synchronizer stages, so the bench waits several edges after raising rst_n before it drives its first vector.

// File: rtl/alu4_mode_pkg.sv
package alu4_mode_pkg;
  localparam int SEL_W = 4;

  typedef struct packed {
    logic             mode_logic;
    logic [SEL_W-1:0] sel;
    logic             carry_in;
  } alu_ctrl_t;
endpackage

// File: rtl/alu4_rst_sync.sv
module alu4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/alu4_operand_stage.sv
module alu4_operand_stage
  import alu4_mode_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] a_d,
  input  logic [W-1:0] b_d,
  input  alu_ctrl_t    ctrl_d,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output alu_ctrl_t    ctrl_q
);
  logic [W-1:0] a_nxt;
  logic [W-1:0] b_nxt;
  alu_ctrl_t    ctrl_nxt;

  // next-state: explicit clock enable
  always_comb begin
    a_nxt    = a_q;
    b_nxt    = b_q;
    ctrl_nxt = ctrl_q;
    if (en) begin
      a_nxt    = a_d;
      b_nxt    = b_d;
      ctrl_nxt = ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      ctrl_q <= '0;
    end else begin
      a_q    <= a_nxt;
      b_q    <= b_nxt;
      ctrl_q <= ctrl_nxt;
    end
  end
endmodule

// File: rtl/alu4_term_gen.sv
module alu4_term_gen
  import alu4_mode_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     x_term,
  output logic [W-1:0]     y_term
);
  // per-bit operand shaping; the select gates B and its complement
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign x_term[i] = a[i] | (b[i] & sel[0]) | (~b[i] & sel[1]);
    assign y_term[i] = (a[i] & b[i] & sel[3]) | (a[i] & ~b[i] & sel[2]);
  end
endmodule

// File: rtl/alu4_ripple_chain.sv
module alu4_ripple_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_term,
  input  logic [W-1:0] y_term,
  input  logic         cin,
  input  logic         logic_mode,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         grp_gen,
  output logic         grp_prop
);
  logic [W-1:0] gen_bit;
  logic [W-1:0] prop_bit;
  logic [W-1:0] sum_bit;
  logic [W-1:0] lgc_bit;
  logic [W:0]   carry;
  logic [W:0]   gen_chain;

  assign carry[0]     = cin;
  assign gen_chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign gen_bit[i]      = x_term[i] & y_term[i];
    assign prop_bit[i]     = x_term[i] | y_term[i];
    assign carry[i+1]      = gen_bit[i] | (prop_bit[i] & carry[i]);
    assign gen_chain[i+1]  = gen_bit[i] | (prop_bit[i] & gen_chain[i]);
    assign sum_bit[i]      = x_term[i] ^ y_term[i] ^ carry[i];
    assign lgc_bit[i]      = ~(x_term[i] ^ y_term[i]);
  end

  always_comb begin
    if (logic_mode) begin
      result    = lgc_bit;
      carry_out = 1'b0;
      grp_gen   = 1'b0;
      grp_prop  = 1'b0;
    end else begin
      result    = sum_bit;
      carry_out = carry[W];
      grp_gen   = gen_chain[W];
      grp_prop  = &prop_bit;
    end
  end
endmodule

// File: rtl/alu4_mode_core.sv
module alu4_mode_core
  import alu4_mode_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             mode_logic,
  input  logic [SEL_W-1:0] sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             equal_flag,
  output logic             grp_gen,
  output logic             grp_prop
);
  logic             rst_n_int;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  alu_ctrl_t        ctrl_d;
  alu_ctrl_t        ctrl_q;
  logic [WIDTH-1:0] x_term;
  logic [WIDTH-1:0] y_term;

  assign ctrl_d = '{mode_logic: mode_logic, sel: sel, carry_in: carry_in};

  alu4_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  alu4_operand_stage #(.W(WIDTH)) u_operands (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .en     (en),
    .a_d    (a_in),
    .b_d    (b_in),
    .ctrl_d (ctrl_d),
    .a_q    (a_q),
    .b_q    (b_q),
    .ctrl_q (ctrl_q)
  );

  alu4_term_gen #(.W(WIDTH)) u_terms (
    .a      (a_q),
    .b      (b_q),
    .sel    (ctrl_q.sel),
    .x_term (x_term),
    .y_term (y_term)
  );

  alu4_ripple_chain #(.W(WIDTH)) u_chain (
    .x_term     (x_term),
    .y_term     (y_term),
    .cin        (ctrl_q.carry_in),
    .logic_mode (ctrl_q.mode_logic),
    .result     (result),
    .carry_out  (carry_out),
    .grp_gen    (grp_gen),
    .grp_prop   (grp_prop)
  );

  assign equal_flag = &result;
endmodule

// File: rtl/alu4_mode_checker.sv
module alu4_mode_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             mode_logic,
  input logic [3:0]       sel,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             equal_flag,
  input logic             grp_gen,
  input logic             grp_prop
);
  // arm once the synchronized reset has released and one capture edge passed
  logic [1:0] arm_cnt;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt <= '0;
    end else if (arm_cnt != 2'd3) begin
      arm_cnt <= arm_cnt + 2'd1;
    end
  end

  assign armed = (arm_cnt == 2'd3);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(en)) |-> ($stable(result) && $stable(carry_out) &&
                               $stable(grp_gen) && $stable(grp_prop)));

  assert_and_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(en && mode_logic && sel == 4'b1011)) |->
      (result == $past(a_in & b_in)));

  assert_logic_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(en && mode_logic)) |->
      (!carry_out && !grp_gen && !grp_prop));

  assert_sub_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(en && !mode_logic && sel == 4'b0110 && !carry_in && a_in == b_in)) |->
      equal_flag);

  assert_carry_compose_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(en && !mode_logic)) |->
      (carry_out == (grp_gen | (grp_prop & $past(carry_in)))));
endmodule

bind alu4_mode_core alu4_mode_checker #(.WIDTH(WIDTH)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .a_in       (a_in),
  .b_in       (b_in),
  .mode_logic (mode_logic),
  .sel        (sel),
  .carry_in   (carry_in),
  .result     (result),
  .carry_out  (carry_out),
  .equal_flag (equal_flag),
  .grp_gen    (grp_gen),
  .grp_prop   (grp_prop)
);

// File: tb/test_alu4_mode_core.sv
`timescale 1ns/1ps
module test_alu4_mode_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] a_in, b_in, sel;
  logic       mode_logic, carry_in;
  logic [3:0] result;
  logic       carry_out, equal_flag, grp_gen, grp_prop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected state: last captured control set
  logic [3:0] ea, eb, es;
  logic       em, ec;

  always #2.5 clk = ~clk;

  alu4_mode_core i_alu4_mode_core (
    .clk(clk), .rst_n(rst_n), .en(en), .a_in(a_in), .b_in(b_in),
    .mode_logic(mode_logic), .sel(sel), .carry_in(carry_in),
    .result(result), .carry_out(carry_out), .equal_flag(equal_flag),
    .grp_gen(grp_gen), .grp_prop(grp_prop)
  );

  // 5-bit sum per the arithmetic function list
  function automatic logic [4:0] arith_sum(input logic [3:0] a, input logic [3:0] b,
                                           input logic [3:0] s, input logic ci);
    logic [4:0] a5, b5, nb5, ab5, anb5, o5, onb5, m1;
    logic [4:0] t;
    a5 = {1'b0, a}; b5 = {1'b0, b}; nb5 = {1'b0, ~b};
    ab5 = {1'b0, a & b}; anb5 = {1'b0, a & ~b};
    o5 = {1'b0, a | b}; onb5 = {1'b0, a | ~b}; m1 = 5'h0F;
    case (s)
      4'd0:  t = a5;
      4'd1:  t = o5;
      4'd2:  t = onb5;
      4'd3:  t = m1;
      4'd4:  t = a5 + anb5;
      4'd5:  t = o5 + anb5;
      4'd6:  t = a5 + nb5;
      4'd7:  t = anb5 + m1;
      4'd8:  t = a5 + ab5;
      4'd9:  t = a5 + b5;
      4'd10: t = onb5 + ab5;
      4'd11: t = ab5 + m1;
      4'd12: t = a5 + a5;
      4'd13: t = o5 + a5;
      4'd14: t = onb5 + a5;
      default: t = m1 + a5;
    endcase
    return t + {4'd0, ci};
  endfunction

  function automatic logic [3:0] logic_fn(input logic [3:0] a, input logic [3:0] b,
                                          input logic [3:0] s);
    case (s)
      4'd0:  return ~a;
      4'd1:  return ~(a | b);
      4'd2:  return ~a & b;
      4'd3:  return 4'h0;
      4'd4:  return ~(a & b);
      4'd5:  return ~b;
      4'd6:  return a ^ b;
      4'd7:  return a & ~b;
      4'd8:  return ~a | b;
      4'd9:  return ~(a ^ b);
      4'd10: return b;
      4'd11: return a & b;
      4'd12: return 4'hF;
      4'd13: return a | ~b;
      4'd14: return a | b;
      default: return a;
    endcase
  endfunction

  // bit order of the packed expectation: {prop, gen, eq, cout, result}
  function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic m, input logic [3:0] s, input logic ci);
    logic [3:0] f;
    logic [4:0] sm;
    logic [3:0] xt;
    logic c, g, p;
    if (m) begin
      f = logic_fn(a, b, s); c = 1'b0; g = 1'b0; p = 1'b0;
    end else begin
      sm = arith_sum(a, b, s, ci);
      f = sm[3:0]; c = sm[4];
      g = arith_sum(a, b, s, 1'b0) >> 4;
      case (s[1:0])
        2'd0: xt = a;
        2'd1: xt = a | b;
        2'd2: xt = a | ~b;
        default: xt = 4'hF;
      endcase
      p = &xt;
    end
    return {p, g, (f == 4'hF), c, f};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ftag);
    logic [7:0] e;
    e = model(ea, eb, em, es, ec);
    chk(ftag, {4'd0, result}, {4'd0, e[3:0]});
    chk("R6 carry_out", {7'd0, carry_out}, {7'd0, e[4]});
    chk("R8 equal_flag", {7'd0, equal_flag}, {7'd0, e[5]});
    chk("R9 gen/prop", {6'd0, grp_prop, grp_gen}, {6'd0, e[7:6]});
  endtask

  // drive on a falling edge, capture at the rising edge, check one falling edge later
  task automatic apply(input logic e, input logic [3:0] a, input logic [3:0] b,
                       input logic m, input logic [3:0] s, input logic ci);
    @(negedge clk);
    en = e; a_in = a; b_in = b; mode_logic = m; sel = s; carry_in = ci;
    if (e) begin
      ea = a; eb = b; em = m; es = s; ec = ci;
    end
    @(negedge clk);
    check_all(e ? (m ? "R3 logic result" : "R5 arith result") : "R2 hold result");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b0; en = 1'b0; a_in = '0; b_in = '0;
    mode_logic = 1'b0; sel = '0; carry_in = 1'b0;
    ea = '0; eb = '0; em = 1'b0; es = '0; ec = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {grp_prop, grp_gen, equal_flag, carry_out, result}, 8'h00);

    // R4: directed AND example
    apply(1'b1, 4'b1010, 4'b0101, 1'b1, 4'b1011, 1'b0);
    chk("R4 and example", {4'd0, result}, 8'h00);
    apply(1'b1, 4'b1110, 4'b0111, 1'b1, 4'b1011, 1'b1);
    chk("R4 and nonzero", {4'd0, result}, 8'h06);

    // R7: subtract corners
    apply(1'b1, 4'd9, 4'd3, 1'b0, 4'b0110, 1'b1);
    chk("R7 a-b", {3'd0, carry_out, result}, {3'd0, 1'b1, 4'd6});
    apply(1'b1, 4'd3, 4'd9, 1'b0, 4'b0110, 1'b1);
    chk("R7 a<b borrow", {3'd0, carry_out, result}, {3'd0, 1'b0, 4'd10});
    apply(1'b1, 4'd5, 4'd5, 1'b0, 4'b0110, 1'b0);
    chk("R7 equal flag", {7'd0, equal_flag}, 8'h01);
    apply(1'b1, 4'd5, 4'd4, 1'b0, 4'b0110, 1'b0);
    chk("R7 unequal flag", {7'd0, equal_flag}, 8'h00);

    // R2: hold with enable low while inputs move
    apply(1'b1, 4'd7, 4'd8, 1'b0, 4'b1001, 1'b1);
    apply(1'b0, 4'd1, 4'd2, 1'b1, 4'b0000, 1'b0);
    chk("R2 hold value", {3'd0, carry_out, result}, {3'd0, 1'b1, 4'd0});
    apply(1'b0, 4'hF, 4'hF, 1'b0, 4'b1111, 1'b1);

    // full sweep: every control code, operand pair and carry
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++)
              apply(1'b1, a[3:0], b[3:0], m[0], s[3:0], c[0]);

    // random stimulus with random enable
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      apply((r[0] | r[1]), r[7:4], r[11:8], r[12], r[19:16], r[20]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule